// File: doc/BRIEF.md
# Capability Color Check Unit

This unit enforces address-space coloring on capabilities handled by a processing element. Each request carries a capability's tag and object-type field, a privilege flag and an operation code. The unit decodes the variable-length prefix at the top of the object-type field. It compares any embedded color with the element's current color, which is held in a register loaded through a separate configuration port. A mismatching capability that user mode loads or dereferences is either trapped or passed on with its tag stripped. The choice comes from a policy input.

The unit also performs a privileged recolor. This operation gives the input capability the color held in an authorization capability. An unprivileged request is refused, and so is one whose authorization capability is untagged or uncolored. Every request yields exactly one registered result, one cycle later. The result carries an exception flag and a cause code. A small two-state machine, with states ST_IDLE and ST_RESP, tracks whether a result is being presented. It moves from ST_IDLE to ST_RESP when a request is valid, stays in ST_RESP while requests keep arriving, and returns to ST_IDLE on a cycle with no request.

Top module: `cap_color_check`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle of `out_valid` on the next clock edge. `out_valid` is low otherwise. After reset, `out_valid`, `out_tag`, `out_exc` and `out_cause` are all 0.
- R2: The 18-bit object type is decoded from its top bits. A top pattern of `10` means it carries a color in bits 15:0. A leading `0` (software type), `110`, `111110` followed by a 3-bit selector, and every other pattern carry no color. A check request whose object type has no color is passed through with its tag and object type unchanged.
- R3: The current color resets to 0 and is loaded from `cfg_color` at a clock edge where `cfg_we` is high. A request in that same cycle is checked against the previous color.
- R4: A check request is any `op` other than `10`: `00` load, `01` dereference, `11` load. When a check request has `priv`=0, a set tag, a color that differs from the current color and `strip_en`=0, the result has `out_exc`=1, `out_cause`=`01` and `out_tag`=0, with the object type unchanged.
- R5: The same mismatch with `strip_en`=1 gives `out_exc`=0, `out_cause`=`00` and `out_tag`=0, with the object type unchanged.
- R6: A check request whose color matches, whose tag is clear, or which has `priv`=1 is passed through unchanged with no exception.
- R7: A recolor (`op`=`10`) with `priv`=1 and a tagged, colored authorization capability outputs `{2'b10, auth color}` as the object type, keeps the input tag, and raises no exception.
- R8: A recolor with `priv`=0 gives `out_exc`=1, `out_cause`=`10` and `out_tag`=0, whatever the authorization capability is.
- R9: A privileged recolor whose authorization capability is untagged or carries no color gives `out_exc`=1, `out_cause`=`11` and `out_tag`=0.
- R10: A result with `out_exc`=1 always has a nonzero cause and a clear tag. A result with `out_exc`=0 always has cause `00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the current color |
| cfg_color | input | 16 | New current color |
| strip_en | input | 1 | 1: strip the tag on mismatch; 0: trap |
| in_valid | input | 1 | Request valid |
| op | input | 2 | 00 load, 01 dereference, 10 recolor, 11 load |
| priv | input | 1 | Requester is privileged |
| in_tag | input | 1 | Input capability tag |
| in_otype | input | 18 | Input capability object-type field |
| auth_tag | input | 1 | Authorization capability tag |
| auth_otype | input | 18 | Authorization capability object-type field |
| out_valid | output | 1 | Result valid |
| out_tag | output | 1 | Result tag |
| out_otype | output | 18 | Result object-type field |
| out_exc | output | 1 | Exception raised |
| out_cause | output | 2 | 00 none, 01 mismatch, 10 privilege, 11 bad authorization |

## Verification
Check requests are sent with matching colors, mismatching colors, untagged inputs, privileged inputs and every non-color prefix. This separates the prefix decode from the compare and from the privilege bypass. The same mismatch is sent under both policy settings to separate trapping from stripping. Recolor is tried with an unprivileged requester and with untagged and uncolored authorizations, which shows the precedence among the three causes. A color write with a request in the same cycle, followed by back-to-back requests, pins down when a new color takes effect and the one-cycle result timing.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int OTYPE_W = 18;
    localparam int COLOR_W = OTYPE_W - 2;

    typedef enum logic [2:0] {
        OT_SOFT, OT_COLOR, OT_META_B, OT_META_E, OT_RSVD
    } ot_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_MISMATCH = 2'b01,
        CAUSE_PRIV     = 2'b10,
        CAUSE_BADAUTH  = 2'b11
    } cause_e;

    localparam logic [1:0] OP_RECOLOR = 2'b10;

    typedef struct packed {
        logic               tag;
        logic [OTYPE_W-1:0] otype;
        logic               exc;
        cause_e             cause;
    } cc_result_t;
endpackage

// File: rtl/cc_otype_decode.sv
module cc_otype_decode
    import cc_pkg::*;
(
    input  logic [OTYPE_W-1:0] otype,
    output ot_kind_e           kind,
    output logic [COLOR_W-1:0] color
);
    localparam int TOP = OTYPE_W - 1;

    always_comb begin
        if (!otype[TOP])
            kind = OT_SOFT;
        else if (!otype[TOP-1])
            kind = OT_COLOR;
        else if (!otype[TOP-2])
            kind = OT_META_B;
        else if (otype[TOP-3:TOP-5] == 3'b110)
            kind = OT_META_E;
        else
            kind = OT_RSVD;
        color = otype[COLOR_W-1:0];
    end
endmodule

// File: rtl/cc_color_reg.sv
module cc_color_reg #(
    parameter int                 W         = 16,
    parameter logic [W-1:0]       RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] color
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            color <= RESET_VAL;
        else if (we)
            color <= wdata;
    end
endmodule

// File: rtl/cc_resp_fsm.sv
module cc_resp_fsm
    import cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  cc_result_t nxt,
    output logic       out_valid,
    output cc_result_t res
);
    typedef enum logic {ST_IDLE, ST_RESP} state_e;
    state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_RESP;
            ST_RESP: if (!in_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (in_valid)
            res <= nxt;
    end

    assign out_valid = (state == ST_RESP);
endmodule

// File: rtl/cap_color_check.sv
module cap_color_check
    import cc_pkg::*;
#(
    parameter logic [COLOR_W-1:0] COLOR_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [COLOR_W-1:0] cfg_color,
    input  logic               strip_en,
    input  logic               in_valid,
    input  logic [1:0]         op,
    input  logic               priv,
    input  logic               in_tag,
    input  logic [OTYPE_W-1:0] in_otype,
    input  logic               auth_tag,
    input  logic [OTYPE_W-1:0] auth_otype,
    output logic               out_valid,
    output logic               out_tag,
    output logic [OTYPE_W-1:0] out_otype,
    output logic               out_exc,
    output logic [1:0]         out_cause
);
    logic [COLOR_W-1:0] cur_color;
    ot_kind_e           in_kind, au_kind;
    logic [COLOR_W-1:0] in_color, au_color;
    cc_result_t         nxt, res;

    cc_color_reg #(.W(COLOR_W), .RESET_VAL(COLOR_RESET)) u_color (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_color), .color(cur_color)
    );

    cc_otype_decode u_dec_in (.otype(in_otype),   .kind(in_kind), .color(in_color));
    cc_otype_decode u_dec_au (.otype(auth_otype), .kind(au_kind), .color(au_color));

    logic mismatch;
    assign mismatch = in_tag && (in_kind == OT_COLOR) && !priv && (in_color != cur_color);

    always_comb begin
        nxt.tag   = in_tag;
        nxt.otype = in_otype;
        nxt.exc   = 1'b0;
        nxt.cause = CAUSE_NONE;
        if (op == OP_RECOLOR) begin
            if (!priv) begin
                nxt.tag   = 1'b0;
                nxt.exc   = 1'b1;
                nxt.cause = CAUSE_PRIV;
            end else if (!auth_tag || au_kind != OT_COLOR) begin
                nxt.tag   = 1'b0;
                nxt.exc   = 1'b1;
                nxt.cause = CAUSE_BADAUTH;
            end else begin
                nxt.otype = {2'b10, au_color};
            end
        end else if (mismatch) begin
            nxt.tag = 1'b0;
            if (!strip_en) begin
                nxt.exc   = 1'b1;
                nxt.cause = CAUSE_MISMATCH;
            end
        end
    end

    cc_resp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .nxt(nxt),
        .out_valid(out_valid), .res(res)
    );

    assign out_tag   = res.tag;
    assign out_otype = res.otype;
    assign out_exc   = res.exc;
    assign out_cause = res.cause;
endmodule

// File: rtl/cc_checker.sv
module cc_checker
    import cc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         op,
    input logic               priv,
    input logic               in_tag,
    input logic [OTYPE_W-1:0] in_otype,
    input logic               out_valid,
    input logic               out_tag,
    input logic [OTYPE_W-1:0] out_otype,
    input logic               out_exc,
    input logic [1:0]         out_cause
);
    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_PRIV_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_RECOLOR && priv) |=>
        (!out_exc && out_tag == $past(in_tag) && out_otype == $past(in_otype))); // R6
    AST_UNPRIV_RECOLOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_RECOLOR && !priv) |=>
        (out_exc && out_cause == 2'b10 && !out_tag)); // R8
    AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_exc) |-> (out_cause != 2'b00 && !out_tag)); // R10
    AST_NOEXC_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_exc) |-> (out_cause == 2'b00)); // R10
endmodule

bind cap_color_check cc_checker u_chk (.*);

// File: tb/cap_color_check_tb.sv
module cap_color_check_tb;
    import cc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [COLOR_W-1:0] cfg_color = '0;
    logic strip_en = 1'b0, in_valid = 1'b0, priv = 1'b0, in_tag = 1'b0, auth_tag = 1'b0;
    logic [1:0] op = 2'b00;
    logic [OTYPE_W-1:0] in_otype = '0, auth_otype = '0;
    logic out_valid, out_tag, out_exc;
    logic [OTYPE_W-1:0] out_otype;
    logic [1:0] out_cause;

    cap_color_check u_dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic               tag;
        logic [OTYPE_W-1:0] otype;
        logic               exc;
        logic [1:0]         cause;
        int                 cyc;
        string              req;
    } exp_t;

    exp_t q[$];
    int errors = 0, checks = 0, cyc = 0;
    logic [COLOR_W-1:0] model_color = '0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [OTYPE_W-1:0] colored(input logic [COLOR_W-1:0] c);
        return {2'b10, c};
    endfunction

    // Expected result built from the requirement text
    function automatic exp_t model(input logic [1:0] o, input logic p, input logic s,
                                   input logic t, input logic [OTYPE_W-1:0] ot,
                                   input logic at, input logic [OTYPE_W-1:0] aot,
                                   input logic [COLOR_W-1:0] col, input string req);
        exp_t e;
        e.tag = t; e.otype = ot; e.exc = 0; e.cause = 2'b00; e.req = req; e.cyc = 0;
        if (o == 2'b10) begin
            if (!p) begin e.tag = 0; e.exc = 1; e.cause = 2'b10; end
            else if (!at || aot[OTYPE_W-1:OTYPE_W-2] != 2'b10) begin
                e.tag = 0; e.exc = 1; e.cause = 2'b11;
            end else e.otype = {2'b10, aot[COLOR_W-1:0]};
        end else if (t && !p && ot[OTYPE_W-1:OTYPE_W-2] == 2'b10 && ot[COLOR_W-1:0] != col) begin
            e.tag = 0;
            if (!s) begin e.exc = 1; e.cause = 2'b01; end
        end
        return e;
    endfunction

    task automatic send(input logic [1:0] o, input logic p, input logic s, input logic t,
                        input logic [OTYPE_W-1:0] ot, input logic at,
                        input logic [OTYPE_W-1:0] aot, input string req,
                        input bit wr = 0, input logic [COLOR_W-1:0] wc = '0);
        exp_t e;
        @(negedge clk);
        op = o; priv = p; strip_en = s; in_tag = t; in_otype = ot;
        auth_tag = at; auth_otype = aot; in_valid = 1;
        cfg_we = wr; cfg_color = wc;
        e = model(o, p, s, t, ot, at, aot, model_color, req);
        e.cyc = cyc;
        q.push_back(e);
        if (wr) model_color = wc;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 0; cfg_we = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic set_color(input logic [COLOR_W-1:0] c);
        @(negedge clk);
        in_valid = 0; cfg_we = 1; cfg_color = c; model_color = c;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (q.size() == 0) begin
                chk(0, "R1", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc == e.cyc + 1, "R1", "result cycle", cyc, e.cyc + 1);
                chk(out_tag == e.tag && out_otype == e.otype && out_exc == e.exc &&
                    out_cause == e.cause, e.req, "tag/otype/exc/cause",
                    {out_tag, out_otype, out_exc, 9'd0, out_cause},
                    {e.tag, e.otype, e.exc, 9'd0, e.cause});
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    localparam logic [OTYPE_W-1:0] NONE = '0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1", "reset out_valid", out_valid, 0);
        chk(out_tag == 0,   "R1", "reset out_tag", out_tag, 0);
        chk(out_exc == 0,   "R1", "reset out_exc", out_exc, 0);
        chk(out_cause == 0, "R1", "reset out_cause", out_cause, 0);

        // R3 reset color is 0: color 0 matches, color 1 mismatches
        send(2'b00, 0, 0, 1, colored(16'h0000), 0, NONE, "R3");
        send(2'b00, 0, 0, 1, colored(16'h0001), 0, NONE, "R3");
        idle(2);

        set_color(16'h1234);
        send(2'b00, 0, 0, 1, colored(16'h1234), 0, NONE, "R6");
        send(2'b00, 0, 0, 1, colored(16'h4321), 0, NONE, "R4");
        send(2'b01, 0, 0, 1, colored(16'h4321), 0, NONE, "R4");
        send(2'b11, 0, 0, 1, colored(16'hFFFF), 0, NONE, "R4");
        send(2'b00, 0, 1, 1, colored(16'h4321), 0, NONE, "R5");
        send(2'b01, 0, 1, 1, colored(16'h1234), 0, NONE, "R5");
        send(2'b00, 0, 0, 0, colored(16'h4321), 0, NONE, "R6");
        send(2'b01, 1, 0, 1, colored(16'h4321), 0, NONE, "R6");
        idle(2);

        // R2 non-color prefixes pass unchanged
        send(2'b00, 0, 0, 1, 18'h0ABCD, 0, NONE, "R2");
        send(2'b00, 0, 0, 1, {3'b110, 15'h5A5A}, 0, NONE, "R2");
        send(2'b01, 0, 0, 1, {6'b111110, 3'd5, 9'h1F3}, 0, NONE, "R2");
        send(2'b00, 0, 0, 1, {6'b111111, 12'hABC}, 0, NONE, "R2");
        send(2'b00, 0, 0, 1, {6'b111101, 12'h123}, 0, NONE, "R2");
        idle(1);

        // Recolor
        send(2'b10, 1, 0, 1, 18'h00077, 1, colored(16'hBEEF), "R7");
        send(2'b10, 1, 0, 0, colored(16'h1111), 1, colored(16'hCAFE), "R7");
        send(2'b10, 0, 0, 1, 18'h00077, 1, colored(16'hBEEF), "R8");
        send(2'b10, 0, 0, 1, 18'h00077, 0, 18'h0ABCD, "R8");
        send(2'b10, 1, 0, 1, 18'h00077, 0, colored(16'hBEEF), "R9");
        send(2'b10, 1, 0, 1, 18'h00077, 1, 18'h0ABCD, "R9");
        send(2'b10, 1, 1, 1, 18'h00077, 1, {3'b110, 15'h0F0F}, "R9");
        idle(3);

        // R3 write in the same cycle uses the old color, the next request the new one
        send(2'b00, 0, 0, 1, colored(16'h5555), 0, NONE, "R3", 1, 16'h5555);
        send(2'b00, 0, 0, 1, colored(16'h5555), 0, NONE, "R3");
        send(2'b00, 0, 0, 1, colored(16'h1234), 0, NONE, "R3");
        idle(3);

        chk(q.size() == 0, "R1", "results outstanding", q.size(), 0);
        chk(out_valid == 0, "R1", "idle out_valid", out_valid, 0);
        finish_run();
    end
endmodule